// File: doc/BRIEF.md
# Transmit Fail-Safe Timeout Monitor

This block guards a serial bus terminal against a runaway transmitter. It watches a transmit-active indication from the encoder and measures how long one continuous transmission lasts, counting system clock cycles. When a message runs longer than the allowed window (768 µs, which is 9216 cycles of a 12 MHz clock), it raises a sticky fail flag. While the flag is up, a kill output forces both bus drive lines low and blocks any further transmission.

Idle stretches inside a transmission do not restart the measurement unless they are long. An idle run of up to 36 cycles (3 µs) counts as part of the same message, even when a master reset pulse caused it. Only an idle run longer than that ends the message and clears the timer. Once set, the flag stays set until one of two events. The first is the receipt of a valid command word that carries the terminal's own address. The second is a master reset pulse.

Top module: `tx_failsafe_mon`

## Requirements
- R1: A synchronous active-high `rst` clears `fail_flag`, `tx_kill`, the message timer and the idle timer.
- R2: `fail_flag` rises at the clock edge that ends active cycle LIMIT_CYC+1 (default 9217) of one continuous transmission. A transmission of exactly LIMIT_CYC active cycles leaves it low.
- R3: `tx_kill` is high in every cycle that `fail_flag` is high, and low otherwise.
- R4: Once set, `fail_flag` stays high through any pattern of `tx_active`, for as long as neither `own_cmd_hit` nor `mst_clr` is asserted.
- R5: `own_cmd_hit` high for one cycle clears `fail_flag` at that clock edge.
- R6: `own_cmd_hit` also restarts the message timer. After it, a further LIMIT_CYC active cycles do not set the flag, and the next active cycle does.
- R7: An idle run of at most GAP_MAX (default 36) consecutive cycles with `tx_active` low keeps the accumulated message time.
- R8: An idle run of GAP_MAX+1 consecutive cycles clears the message timer, so the next message gets a full LIMIT_CYC window.
- R9: `mst_clr` clears `fail_flag` but keeps the message timer. If the message time has already reached the limit, the next active cycle sets the flag again.
- R10: When a clear request (`own_cmd_hit` or `mst_clr`) falls in the same cycle as an overflow, the clear wins and `fail_flag` stays low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (12 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| tx_active | input | 1 | High while the encoder is driving the bus |
| own_cmd_hit | input | 1 | One-cycle pulse: valid command word with own address received |
| mst_clr | input | 1 | Master reset pulse, active high |
| fail_flag | output | 1 | Sticky fail-safe timeout flag |
| tx_kill | output | 1 | Forces both bus outputs low and blocks transmission |

## Verification
Overflow detection and flag clearing can land on the same clock edge. The bench fills the message timer to exactly the limit. It then drives one more active cycle together with a clear pulse, once with the own-address pulse and once with the master reset. The flag must read low after that edge. After the master-reset case, one further active cycle must set the flag, because the timer was kept. After the own-address case, a full fresh window must pass before the flag sets.

// File: rtl/fs_pkg.sv
package fs_pkg;

    // Default window: 768 us at 12 MHz, gap tolerance 3 us at 12 MHz
    localparam int unsigned DEF_LIMIT_CYC = 9216;
    localparam int unsigned DEF_GAP_MAX   = 36;

    // Per-cycle control requests presented to the timers and flag
    typedef struct packed {
        logic active;    // encoder is transmitting this cycle
        logic own_clr;   // own-address command seen
        logic mst_clr;   // master reset pulse
    } fs_ctl_t;

    // Width needed to hold values 0..maxval
    function automatic int unsigned cnt_width(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

    // Any request that clears the flag
    function automatic logic any_clear(input fs_ctl_t c);
        return c.own_clr | c.mst_clr;
    endfunction

endpackage

// File: rtl/fs_gap_timer.sv
module fs_gap_timer
    import fs_pkg::*;
#(
    parameter int unsigned GAP_MAX = DEF_GAP_MAX
) (
    input  logic    clk,
    input  logic    rst,
    input  fs_ctl_t ctl,
    output logic    gap_expire
);
    localparam int unsigned GW  = cnt_width(GAP_MAX + 1);
    localparam logic [GW-1:0] SAT = GW'(GAP_MAX + 1);
    localparam logic [GW-1:0] EDGE = GW'(GAP_MAX);

    logic [GW-1:0] idle_q;

    // This idle cycle is idle cycle GAP_MAX+1 of the run
    assign gap_expire = !ctl.active && (idle_q == EDGE);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= '0;
        end else if (ctl.active) begin
            idle_q <= '0;
        end else if (idle_q != SAT) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    a_r7_idle_bounded: assert property (@(posedge clk) disable iff (rst)
        idle_q <= SAT);

    a_r7_active_zeroes_idle: assert property (@(posedge clk) disable iff (rst)
        ctl.active |=> (idle_q == '0));

endmodule

// File: rtl/fs_msg_timer.sv
module fs_msg_timer
    import fs_pkg::*;
#(
    parameter int unsigned LIMIT_CYC = DEF_LIMIT_CYC
) (
    input  logic    clk,
    input  logic    rst,
    input  fs_ctl_t ctl,
    input  logic    gap_expire,
    output logic    overflow
);
    localparam int unsigned MW = cnt_width(LIMIT_CYC);
    localparam logic [MW-1:0] TOP = MW'(LIMIT_CYC);

    logic [MW-1:0] len_q;
    logic          at_top;

    assign at_top = (len_q == TOP);

    // An active cycle beyond the window; an own-address clear pre-empts it
    assign overflow = ctl.active && at_top && !ctl.own_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
        end else if (ctl.own_clr || gap_expire) begin
            len_q <= '0;
        end else if (ctl.active && !at_top) begin
            len_q <= len_q + 1'b1;
        end
    end

    a_r2_len_saturates: assert property (@(posedge clk) disable iff (rst)
        len_q <= TOP);

    a_r8_gap_restarts: assert property (@(posedge clk) disable iff (rst)
        gap_expire |=> (len_q == '0));

    a_r6_own_restarts: assert property (@(posedge clk) disable iff (rst)
        ctl.own_clr |=> (len_q == '0));

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!ctl.active && !gap_expire && !ctl.own_clr) |=> $stable(len_q));

    a_r9_mst_keeps_len: assert property (@(posedge clk) disable iff (rst)
        (ctl.mst_clr && !ctl.own_clr && !gap_expire && !ctl.active) |=> $stable(len_q));

endmodule

// File: rtl/fs_flag_ctl.sv
module fs_flag_ctl
    import fs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  fs_ctl_t ctl,
    input  logic    overflow,
    output logic    flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (any_clear(ctl)) begin
            flag_q <= 1'b0;
        end else if (overflow) begin
            flag_q <= 1'b1;
        end
    end

    assign flag = flag_q;

    a_r2_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ctl.own_clr && !ctl.mst_clr) |=> flag_q);

    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !ctl.own_clr && !ctl.mst_clr) |=> flag_q);

    a_r5_own_clears: assert property (@(posedge clk) disable iff (rst)
        ctl.own_clr |=> !flag_q);

    a_r9_mst_clears: assert property (@(posedge clk) disable iff (rst)
        ctl.mst_clr |=> !flag_q);

    a_r10_rise_needs_overflow: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(overflow));

endmodule

// File: rtl/tx_failsafe_mon.sv
module tx_failsafe_mon
    import fs_pkg::*;
#(
    parameter int unsigned LIMIT_CYC = DEF_LIMIT_CYC,
    parameter int unsigned GAP_MAX   = DEF_GAP_MAX
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_active,
    input  logic own_cmd_hit,
    input  logic mst_clr,
    output logic fail_flag,
    output logic tx_kill
);
    fs_ctl_t ctl;
    logic    gap_expire;
    logic    overflow;
    logic    flag;

    always_comb begin
        ctl.active  = tx_active;
        ctl.own_clr = own_cmd_hit;
        ctl.mst_clr = mst_clr;
    end

    fs_gap_timer #(.GAP_MAX(GAP_MAX)) u_gap (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .gap_expire (gap_expire)
    );

    fs_msg_timer #(.LIMIT_CYC(LIMIT_CYC)) u_msg (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .gap_expire (gap_expire),
        .overflow   (overflow)
    );

    fs_flag_ctl u_flag (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .overflow (overflow),
        .flag     (flag)
    );

    assign fail_flag = flag;
    assign tx_kill   = flag;

    a_r3_kill_follows_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_kill) |-> $past(tx_active));

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !fail_flag);

endmodule

// File: tb/sim_tx_failsafe_mon.sv
module sim_tx_failsafe_mon;
    localparam int LIM = 9216;
    localparam int GAP = 36;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_active = 1'b0;
    logic own_cmd_hit = 1'b0;
    logic mst_clr = 1'b0;
    logic fail_flag;
    logic tx_kill;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tx_failsafe_mon #(.LIMIT_CYC(LIM), .GAP_MAX(GAP)) u0 (
        .clk(clk), .rst(rst), .tx_active(tx_active),
        .own_cmd_hit(own_cmd_hit), .mst_clr(mst_clr),
        .fail_flag(fail_flag), .tx_kill(tx_kill)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_out(input string req, input logic exp);
        chk({req, " fail_flag"}, fail_flag, exp);
        chk({"R3 ", req, " tx_kill"}, tx_kill, exp);
    endtask

    // Entered at a negedge; each cycle sets inputs then waits through one posedge
    task automatic drive(input logic act, input int n);
        for (int i = 0; i < n; i++) begin
            tx_active = act;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input logic act, input logic own, input logic mst);
        tx_active = act; own_cmd_hit = own; mst_clr = mst;
        @(negedge clk);
        own_cmd_hit = 1'b0; mst_clr = 1'b0;
    endtask

    task automatic do_reset();
        tx_active = 1'b0; own_cmd_hit = 1'b0; mst_clr = 1'b0;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk_out("R1 reset", 1'b0);
        // leave a saturated count behind, then reset: full window must follow
        drive(1'b1, LIM + 1);
        do_reset();
        chk_out("R1 reset clears flag", 1'b0);
        drive(1'b1, LIM);
        chk_out("R1 timer cleared by reset", 1'b0);
        drive(1'b0, 1);
    endtask

    task automatic t_exact_limit();
        do_reset();
        drive(1'b1, LIM);
        chk_out("R2 exactly limit", 1'b0);
        drive(1'b1, 1);
        chk_out("R2 limit plus one", 1'b1);
        drive(1'b0, 100);
        chk_out("R4 sticky while idle", 1'b1);
        drive(1'b1, 50);
        chk_out("R4 sticky while active", 1'b1);
        pulse(1'b0, 1'b1, 1'b0);
        chk_out("R5 own cmd clears", 1'b0);
        drive(1'b1, LIM);
        chk_out("R6 fresh window after own cmd", 1'b0);
        drive(1'b1, 1);
        chk_out("R6 overflow after fresh window", 1'b1);
        drive(1'b0, 1);
    endtask

    task automatic t_short_gap();
        do_reset();
        drive(1'b1, 5000);
        drive(1'b0, GAP);
        drive(1'b1, LIM - 5000);
        chk_out("R7 short gap keeps time", 1'b0);
        drive(1'b1, 1);
        chk_out("R7 short gap overflow", 1'b1);
        drive(1'b0, 1);
    endtask

    task automatic t_long_gap();
        do_reset();
        drive(1'b1, 5000);
        drive(1'b0, GAP + 1);
        drive(1'b1, LIM);
        chk_out("R8 long gap restarts", 1'b0);
        drive(1'b1, 1);
        chk_out("R8 overflow after restart", 1'b1);
        drive(1'b0, 1);
    endtask

    task automatic t_mst();
        do_reset();
        drive(1'b1, LIM + 1);
        chk_out("R9 flag up before mst", 1'b1);
        pulse(1'b0, 1'b0, 1'b1);
        chk_out("R9 mst clears flag", 1'b0);
        drive(1'b1, 1);
        chk_out("R9 timer kept, flag returns", 1'b1);
        drive(1'b0, 1);
    endtask

    task automatic t_collide();
        do_reset();
        drive(1'b1, LIM);
        pulse(1'b1, 1'b1, 1'b0);
        chk_out("R10 own cmd beats overflow", 1'b0);
        drive(1'b1, LIM);
        chk_out("R10 own cmd restarted timer", 1'b0);
        pulse(1'b1, 1'b0, 1'b1);
        chk_out("R10 mst beats overflow", 1'b0);
        drive(1'b1, 1);
        chk_out("R10 flag sets after mst collision", 1'b1);
        drive(1'b0, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_exact_limit();
        t_short_gap();
        t_long_gap();
        t_mst();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule